// File: doc/BRIEF.md
# Oscillator Clock Loss Monitor

This block watches an oscillator clock and reports when it stops. The time base is a separate free-running reference clock, so the time-out still runs when the watched clock is dead. Each oscillator rising edge flips a toggle flop in the oscillator domain. The toggle passes through a synchronizer chain into the reference domain, and every change seen there restarts a saturating time-out counter. If the counter reaches its limit while the monitor is enabled, a clock failure is flagged for one reference cycle.

A mode input selects the response to a failure. With the mode low, the block asserts a reset request for a fixed number of reference cycles. It then returns to idle and watches again with a fresh window. With the mode high, the block enters self clock mode. In that mode the clock output is taken from the PLL clock, which the system holds at its minimum frequency, in place of the oscillator clock. Self clock mode is sticky. It can be left only after the oscillator has produced edges, with no gap, for one full time-out window and software then pulses a clear input.

The controller has five states. IDLE: the monitor is off or restarting, and the counter is held at zero. WATCH: the window is being timed. RESET_REQ: the reset request pulse is being driven. SELF_CLK: the oscillator is lost and the PLL clock drives the output. SELF_CLK_OK: the oscillator is back and the block waits for the clear.

The transitions are:
- IDLE to WATCH when enable is high.
- WATCH to IDLE when enable drops.
- WATCH to RESET_REQ on a time-out with the mode low.
- WATCH to SELF_CLK on a time-out with the mode high.
- RESET_REQ to IDLE when the pulse ends.
- SELF_CLK to SELF_CLK_OK when a full window has passed without a time-out.
- SELF_CLK_OK to SELF_CLK on a new time-out.
- SELF_CLK_OK to IDLE when the clear is pulsed.

Top module: `osc_loss_monitor`

## Requirements
- R1: While enabled and the oscillator toggles with a period well inside the time-out window, `clk_fail_o` never pulses and neither `rst_req_o` nor `scm_o` is asserted.
- R2: When the oscillator stops while in WATCH, `clk_fail_o` pulses for one reference cycle. The pulse comes TIMEOUT_CYC cycles plus the synchronizer latency after the last edge.
- R3: With `scm_en` low, a failure makes `rst_req_o` high in the next cycle for exactly RST_LEN consecutive cycles, and `scm_o` stays low.
- R4: With `scm_en` high, a failure makes `scm_o` high in the next cycle, and `rst_req_o` is not asserted.
- R5: `clk_out_o` equals `pll_clk` while `scm_o` is high and equals `osc_clk` otherwise. `rst_req_o` and `scm_o` are never high together.
- R6: While `mon_en` is low, `clk_fail_o` stays low and no reset request or self clock mode is started, even with the oscillator stopped.
- R7: After a reset request ends, the monitor passes through IDLE and times a complete new window. If the oscillator is still dead, the next failure comes between TIMEOUT_CYC and TIMEOUT_CYC+3 cycles after `rst_req_o` falls.
- R8: `scm_o` is sticky. A `scm_clr` pulse has no effect while the oscillator is dead or before a full window of edges has passed, and dropping `mon_en` does not leave the mode.
- R9: Once edges have been seen for a full time-out window without a gap, a `scm_clr` pulse drops `scm_o` within two cycles.
- R10: During and directly after reset, `clk_fail_o`, `rst_req_o` and `scm_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock, independent of the watched clock |
| ref_rst_n | input | 1 | Active-low asynchronous reset |
| osc_clk | input | 1 | Oscillator clock under watch |
| pll_clk | input | 1 | PLL clock used as the fallback source in self clock mode |
| mon_en | input | 1 | Monitor enable |
| scm_en | input | 1 | Failure response: 0 requests reset, 1 enters self clock mode |
| scm_clr | input | 1 | One-cycle software clear for self clock mode |
| clk_fail_o | output | 1 | One-cycle pulse on a detected failure |
| rst_req_o | output | 1 | Clock-loss reset request, RST_LEN cycles long |
| scm_o | output | 1 | Self clock mode active |
| clk_out_o | output | 1 | Selected clock: osc_clk normally, pll_clk in self clock mode |

## Verification
The assertions check the following on every cycle:
- a failure can never be flagged while the monitor is disabled;
- a failure is followed by the response chosen by the mode input;
- the reset pulse has exactly the set length;
- the reset request and self clock mode never overlap;
- self clock mode is left only after a clear;
- the clock output follows the selected source.

Some behaviours can be shown only by the bench scenarios, because they depend on the gap between real oscillator edges:
- when a failure fires after the oscillator stops;
- that no failure fires under randomly chosen oscillator periods;
- that a full new window is timed after a reset request;
- that the clear is refused until the oscillator has been running for a whole window.

// File: rtl/osc_mon_pkg.sv
package osc_mon_pkg;

    typedef enum logic [2:0] {
        MON_IDLE      = 3'd0,
        MON_WATCH     = 3'd1,
        MON_RESET_REQ = 3'd2,
        MON_SELF_CLK  = 3'd3,
        MON_SELF_OK   = 3'd4
    } mon_state_e;

    function automatic logic in_self_clock(input mon_state_e s);
        return (s == MON_SELF_CLK) || (s == MON_SELF_OK);
    endfunction

endpackage

// File: rtl/osc_mon_edge_sync.sv
module osc_mon_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic osc_clk,
    input  logic ref_clk,
    input  logic rst_n,
    output logic edge_o
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic       osc_tog;
    logic [CHAIN_W-1:0] chain;

    // Toggle flop in the watched domain: one flip per rising edge.
    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) osc_tog <= 1'b0;
        else        osc_tog <= ~osc_tog;
    end

    // Synchronizer stages plus one history flop for change detection.
    generate
        for (genvar i = 0; i < CHAIN_W; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge ref_clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= osc_tog;
                end
            end else begin : g_next
                always_ff @(posedge ref_clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign edge_o = chain[CHAIN_W-1] ^ chain[CHAIN_W-2];

endmodule

// File: rtl/osc_mon_sat_ctr.sv
module osc_mon_sat_ctr #(
    parameter int LIMIT = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    output logic [$clog2(LIMIT+1)-1:0] cnt_o,
    output logic                       sat_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (clr)        cnt_q <= '0;
        else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;
    assign sat_o = (cnt_q == LIM);

endmodule

// File: rtl/osc_mon_fsm.sv
module osc_mon_fsm
    import osc_mon_pkg::*;
#(
    parameter int RST_LEN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mon_en,
    input  logic       scm_en,
    input  logic       scm_clr,
    input  logic       to_expired,
    input  logic       recov_done,
    output mon_state_e state_o,
    output logic       to_hold_clr,
    output logic       recov_clr,
    output logic       fail_o,
    output logic       rst_req_o,
    output logic       scm_o
);
    localparam int PW = $clog2(RST_LEN + 1);
    localparam logic [PW-1:0] PLAST = PW'(RST_LEN - 1);

    mon_state_e state_q, state_d;
    logic [PW-1:0] plen_q;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MON_IDLE: begin
                if (mon_en) state_d = MON_WATCH;
            end
            MON_WATCH: begin
                if (!mon_en)        state_d = MON_IDLE;
                else if (to_expired) state_d = scm_en ? MON_SELF_CLK : MON_RESET_REQ;
            end
            MON_RESET_REQ: begin
                if (plen_q == PLAST) state_d = MON_IDLE;
            end
            MON_SELF_CLK: begin
                if (recov_done) state_d = MON_SELF_OK;
            end
            MON_SELF_OK: begin
                if (to_expired)   state_d = MON_SELF_CLK;
                else if (scm_clr) state_d = MON_IDLE;
            end
            default: state_d = MON_IDLE;
        endcase
    end

    // State register and pulse-length counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MON_IDLE;
            plen_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == MON_RESET_REQ) plen_q <= plen_q + 1'b1;
            else                          plen_q <= '0;
        end
    end

    // Outputs.
    always_comb begin
        state_o     = state_q;
        to_hold_clr = (state_q == MON_IDLE);
        recov_clr   = !in_self_clock(state_q) || to_expired;
        fail_o      = (state_q == MON_WATCH) && mon_en && to_expired;
        rst_req_o   = (state_q == MON_RESET_REQ);
        scm_o       = in_self_clock(state_q);
    end

endmodule

// File: rtl/osc_loss_monitor.sv
module osc_loss_monitor
    import osc_mon_pkg::*;
#(
    parameter int TIMEOUT_CYC = 64,
    parameter int RST_LEN     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic ref_rst_n,
    input  logic osc_clk,
    input  logic pll_clk,
    input  logic mon_en,
    input  logic scm_en,
    input  logic scm_clr,
    output logic clk_fail_o,
    output logic rst_req_o,
    output logic scm_o,
    output logic clk_out_o
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);

    logic          osc_edge;
    logic [CW-1:0] to_cnt, rc_cnt;
    logic          to_expired, recov_done, to_hold_clr, recov_clr;
    mon_state_e    state;

    osc_mon_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .osc_clk (osc_clk),
        .ref_clk (ref_clk),
        .rst_n   (ref_rst_n),
        .edge_o  (osc_edge)
    );

    // Time-out counter: restarted by every oscillator edge.
    osc_mon_sat_ctr #(.LIMIT(TIMEOUT_CYC)) u_timeout (
        .clk   (ref_clk),
        .rst_n (ref_rst_n),
        .clr   (osc_edge || to_hold_clr),
        .cnt_o (to_cnt),
        .sat_o (to_expired)
    );

    // Recovery counter: counts gap-free cycles while in self clock mode.
    osc_mon_sat_ctr #(.LIMIT(TIMEOUT_CYC)) u_recov (
        .clk   (ref_clk),
        .rst_n (ref_rst_n),
        .clr   (recov_clr),
        .cnt_o (rc_cnt),
        .sat_o (recov_done)
    );

    osc_mon_fsm #(.RST_LEN(RST_LEN)) u_fsm (
        .clk         (ref_clk),
        .rst_n       (ref_rst_n),
        .mon_en      (mon_en),
        .scm_en      (scm_en),
        .scm_clr     (scm_clr),
        .to_expired  (to_expired),
        .recov_done  (recov_done),
        .state_o     (state),
        .to_hold_clr (to_hold_clr),
        .recov_clr   (recov_clr),
        .fail_o      (clk_fail_o),
        .rst_req_o   (rst_req_o),
        .scm_o       (scm_o)
    );

    assign clk_out_o = scm_o ? pll_clk : osc_clk;

endmodule

// File: rtl/osc_mon_checker.sv
module osc_mon_checker #(
    parameter int RST_LEN = 4
) (
    input logic ref_clk,
    input logic ref_rst_n,
    input logic osc_clk,
    input logic pll_clk,
    input logic mon_en,
    input logic scm_en,
    input logic scm_clr,
    input logic clk_fail_o,
    input logic rst_req_o,
    input logic scm_o,
    input logic clk_out_o
);
    localparam int RW = $clog2(RST_LEN + 1) + 1;
    logic [RW-1:0] run_q;

    always_ff @(posedge ref_clk or negedge ref_rst_n) begin
        if (!ref_rst_n)     run_q <= '0;
        else if (rst_req_o) run_q <= run_q + 1'b1;
        else                run_q <= '0;
    end

    a_r6_no_fail_disabled: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        !mon_en |-> !clk_fail_o);

    a_r3_reset_follows: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        (clk_fail_o && !scm_en) |=> (rst_req_o && !scm_o));

    a_r4_scm_follows: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        (clk_fail_o && scm_en) |=> (scm_o && !rst_req_o));

    a_r3_pulse_max: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        rst_req_o |-> (run_q < RW'(RST_LEN)));

    a_r3_pulse_len: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        $fell(rst_req_o) |-> (run_q == RW'(RST_LEN)));

    a_r5_exclusive: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        !(rst_req_o && scm_o));

    a_r5_clk_select: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        clk_out_o == (scm_o ? pll_clk : osc_clk));

    a_r8_scm_sticky: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        $fell(scm_o) |-> $past(scm_clr));

endmodule

bind osc_loss_monitor osc_mon_checker #(.RST_LEN(RST_LEN)) u_chk (
    .ref_clk    (ref_clk),
    .ref_rst_n  (ref_rst_n),
    .osc_clk    (osc_clk),
    .pll_clk    (pll_clk),
    .mon_en     (mon_en),
    .scm_en     (scm_en),
    .scm_clr    (scm_clr),
    .clk_fail_o (clk_fail_o),
    .rst_req_o  (rst_req_o),
    .scm_o      (scm_o),
    .clk_out_o  (clk_out_o)
);

// File: tb/osc_loss_monitor_bench.sv
`timescale 1ns/1ps
module osc_loss_monitor_bench;
    localparam int T  = 64;
    localparam int RL = 4;

    logic ref_clk = 1'b0, ref_rst_n = 1'b0, osc_clk = 1'b0, pll_clk = 1'b0;
    logic mon_en = 1'b0, scm_en = 1'b0, scm_clr = 1'b0;
    logic clk_fail_o, rst_req_o, scm_o, clk_out_o;

    bit osc_run = 1'b0;
    int osc_half = 10;
    int vectors = 0, miscompares = 0;
    int fail_seen = 0, rst_seen = 0, mux_bad = 0;

    osc_loss_monitor #(.TIMEOUT_CYC(T), .RST_LEN(RL), .SYNC_STAGES(2)) u_osc_loss_monitor (
        .ref_clk, .ref_rst_n, .osc_clk, .pll_clk, .mon_en, .scm_en, .scm_clr,
        .clk_fail_o, .rst_req_o, .scm_o, .clk_out_o
    );

    always #2 ref_clk = ~ref_clk;

    // Toggles on x.5 ns times so they never coincide with sampling edges.
    initial begin
        #0.5;
        forever #3 pll_clk = ~pll_clk;
    end
    initial begin
        #0.5;
        forever begin
            if (osc_run) #(osc_half) osc_clk = ~osc_clk;
            else #1;
        end
    end

    always @(negedge ref_clk) begin
        if (ref_rst_n) begin
            if (clk_fail_o) fail_seen++;
            if (rst_req_o)  rst_seen++;
            if (clk_out_o !== (scm_o ? pll_clk : osc_clk)) mux_bad++;
        end
    end

    function automatic int fail_lo();  return T - 4; endfunction
    function automatic int fail_hi();  return T + 6; endfunction
    function automatic int regap_lo(); return T;     endfunction
    function automatic int regap_hi(); return T + 3; endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_clr();
        scm_clr = 1'b1;
        @(negedge ref_clk);
        scm_clr = 1'b0;
    endtask

    task automatic wait_fail(output int n);
        n = 0;
        do begin
            @(negedge ref_clk);
            n++;
        end while (!clk_fail_o && n < 2000);
    endtask

    initial begin
        #400000;
        miscompares++;
        $display("FAIL watchdog expired (all requirements) actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int n, len, f0, r0;
        void'($urandom(32'd1234));
        repeat (5) @(negedge ref_clk);
        // R10: reset state
        chk(clk_fail_o == 0, "R10 fail in reset", clk_fail_o, 0);
        chk(rst_req_o == 0,  "R10 rst_req in reset", rst_req_o, 0);
        chk(scm_o == 0,      "R10 scm in reset", scm_o, 0);
        ref_rst_n = 1'b1;
        @(negedge ref_clk);
        chk(!clk_fail_o && !rst_req_o && !scm_o, "R10 after release", {clk_fail_o, rst_req_o, scm_o}, 0);

        // R1: random oscillator periods, random mode
        osc_run = 1'b1;
        mon_en  = 1'b1;
        for (int seg = 0; seg < 6; seg++) begin
            osc_half = 3 + int'($urandom % 18);
            scm_en   = 1'($urandom % 2);
            f0 = fail_seen; r0 = rst_seen;
            repeat (400 + int'($urandom % 400)) @(negedge ref_clk);
            chk(fail_seen == f0, "R1 no failure while running", fail_seen - f0, 0);
            chk(rst_seen == r0 && !scm_o, "R1 no response while running", rst_seen - r0, 0);
        end
        chk(mux_bad == 0, "R5 clock select on oscillator", mux_bad, 0);

        // R2/R3: stop oscillator with reset response
        osc_half = 10; scm_en = 1'b0;
        repeat (50) @(negedge ref_clk);
        osc_run = 1'b0;
        wait_fail(n);
        chk(n >= fail_lo() && n <= fail_hi(), "R2 failure latency", n, T + 4);
        @(negedge ref_clk);
        chk(rst_req_o == 1, "R3 reset request follows failure", rst_req_o, 1);
        len = 0;
        while (rst_req_o && len < 100) begin
            chk(scm_o == 0, "R3 no self clock during reset", scm_o, 0);
            len++;
            @(negedge ref_clk);
        end
        chk(len == RL, "R3 reset pulse length", len, RL);

        // R7: fresh window after restart
        wait_fail(n);
        chk(n >= regap_lo() && n <= regap_hi(), "R7 window after restart", n, T + 1);
        repeat (RL + 3) @(negedge ref_clk);

        // R6: disabled with dead oscillator
        mon_en = 1'b0;
        @(negedge ref_clk);
        f0 = fail_seen; r0 = rst_seen;
        repeat (600) @(negedge ref_clk);
        chk(fail_seen == f0, "R6 no failure while disabled", fail_seen - f0, 0);
        chk(rst_seen == r0, "R6 no reset while disabled", rst_seen - r0, 0);
        chk(scm_o == 0, "R6 no self clock while disabled", scm_o, 0);

        // R4: self clock response
        scm_en = 1'b1; mon_en = 1'b1;
        wait_fail(n);
        chk(n <= T + 4, "R4 failure after enable", n, T + 2);
        @(negedge ref_clk);
        chk(scm_o == 1, "R4 self clock entered", scm_o, 1);
        chk(rst_req_o == 0, "R4 no reset request", rst_req_o, 0);
        repeat (40) @(negedge ref_clk);
        chk(mux_bad == 0, "R5 clock select on pll", mux_bad, 0);
        chk(rst_seen == r0, "R5 reset and self clock exclusive", rst_seen - r0, 0);

        // R8: sticky self clock mode
        pulse_clr();
        repeat (5) @(negedge ref_clk);
        chk(scm_o == 1, "R8 clear ignored while dead", scm_o, 1);
        mon_en = 1'b0;
        repeat (5) @(negedge ref_clk);
        chk(scm_o == 1, "R8 disable keeps self clock", scm_o, 1);
        mon_en = 1'b1;
        osc_run = 1'b1;
        repeat (T / 2) @(negedge ref_clk);
        pulse_clr();
        repeat (3) @(negedge ref_clk);
        chk(scm_o == 1, "R8 clear ignored before full window", scm_o, 1);

        // R9: clear after recovery
        repeat (2 * T) @(negedge ref_clk);
        pulse_clr();
        repeat (2) @(negedge ref_clk);
        chk(scm_o == 0, "R9 clear after recovery", scm_o, 0);
        chk(rst_req_o == 0, "R9 no reset on exit", rst_req_o, 0);
        f0 = fail_seen;
        repeat (500) @(negedge ref_clk);
        chk(fail_seen == f0, "R1 running after recovery", fail_seen - f0, 0);
        chk(mux_bad == 0, "R5 clock select overall", mux_bad, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule